// File: doc/BRIEF.md
# Error-Correcting Byte Static Memory

This block is a byte-wide static memory that protects every stored byte with a single-error-correcting, double-error-detecting code. Each write turns the incoming byte into a 13-bit codeword and stores it. Each read decodes the codeword, repairs one flipped bit if there is one, and reports the repair on an error flag. The repaired value is never written back. The stored word keeps its fault, so every later read of it reports the error again until software overwrites the location.

Access is controlled in the style of an asynchronous memory chip, but every control is sampled on a clock. Two chip enables must agree before anything happens: the active-low one must be low and the active-high one must be high. A write needs write enable low. A read needs output enable low and write enable high. Read data, the drive-enable for the data bus and the flags are all registered, so they appear one cycle after the controls are sampled. The bidirectional data bus is split into an input, an output and an output-enable.

The address port is 21 bits wide. The number of words actually built is a parameter, so the array stays small enough to simulate. A fault-injection port lets a test XOR any bit pattern into the stored codeword at any address.

Top module: `ecc_sram`

## Requirements
- R1: The memory is selected only when `ce1_n` is 0 and `ce2` is 1. Under any other combination, no write changes the array, and `dq_oe` is 0 in the following cycle.
- R2: A selected cycle with `we_n` 0 stores `dq_in` at the word given by `addr`. The value of `oe_n` does not matter.
- R3: A selected cycle with `oe_n` 0 and `we_n` 1 is a read. After the next rising clock edge, `dq_oe` is 1 and `dq_out` holds the stored byte.
- R4: `dq_oe` is 0 in the cycle after any of these: a deselected cycle, a cycle with `oe_n` high, or a write cycle.
- R5: The codeword has this layout:
  - Bit 0 is an overall parity bit.
  - Bits 1 to 12 are Hamming positions 1 to 12.
  - Check bits sit at positions 1, 2, 4 and 8.
  - Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.

  If exactly one of the 13 bits is flipped, a read returns the original byte with `err` at 1 and `ue` at 0.
- R6: A corrected word is not written back. A second read of the same faulty word again returns the corrected byte with `err` at 1.
- R7: If exactly two codeword bits are flipped, a read leaves the byte uncorrected. It returns the data bits as they are stored, with `err` at 0 and `ue` at 1. `err` and `ue` are never both 1.
- R8: `err` and `ue` are both 0 whenever `dq_oe` is 0, which covers writes and deselected cycles.
- R9: When `inj_en` is 1 at a rising edge, `inj_mask` is XORed into the codeword at `inj_addr`. If a write takes place in the same cycle, the write wins and the injection is dropped.
- R10: After a clock edge with `rst_n` at 0, `dq_oe`, `dq_out`, `err` and `ue` are all 0.
- R11: Only the low log2(DEPTH) address bits select a word. Addresses that differ only above those bits refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| ce1_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 21 | Word address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Registered read data |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| err | output | 1 | A single-bit error was corrected on this read |
| ue | output | 1 | An uncorrectable double-bit error was detected on this read |
| inj_en | input | 1 | Fault injection strobe |
| inj_addr | input | 21 | Word address for fault injection |
| inj_mask | input | 13 | Bits to flip in the stored codeword |

## Verification
The hardest states to reach from the ports are a stored codeword with one or two bits flipped. A normal write can only produce a valid codeword, so these states never arise through ordinary use.

The bench first writes a known byte. It then uses the injection port to flip each of the 13 codeword positions in turn, and it flips selected pairs that cover data bits, check bits and the overall parity bit. Each corrupted word is read twice, which shows both the correction and the absence of write-back. Finally, the bench drives a write and an injection in the same cycle to show that the write takes priority.

// File: rtl/ecc_sram_pkg.sv
// Shared constants and types for the ECC-protected byte memory.
// Assumes a Hamming code over DATA_W bits with PAR_W check bits, plus one overall parity bit.
package ecc_sram_pkg;
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int HAM_N  = DATA_W + PAR_W;
    localparam int CW_W   = HAM_N + 1;

    typedef logic [CW_W-1:0]   codeword_t;
    typedef logic [DATA_W-1:0] byte_t;

    // True when pos is a power of two, i.e. a check-bit position
    function automatic logic is_check_pos(input int pos);
        return (pos & (pos - 1)) == 0;
    endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
// Encoder: maps a byte onto a SEC-DED codeword.
// Layout: bit 0 is overall parity; bits 1..HAM_N are Hamming positions,
// with check bits at the power-of-two positions and data bits in ascending order elsewhere.
module ecc_sram_enc
    import ecc_sram_pkg::*;
(
    input  byte_t     data,
    output codeword_t cw
);
    codeword_t ham;

    // Place data bits, then compute check bits and overall parity
    always_comb begin
        int d;
        ham = '0;
        d = 0;
        for (int pos = 1; pos <= HAM_N; pos++) begin
            if (!is_check_pos(pos)) begin
                ham[pos] = data[d];
                d = d + 1;
            end
        end
        for (int k = 0; k < PAR_W; k++) begin
            logic p;
            p = 1'b0;
            for (int pos = 1; pos <= HAM_N; pos++) begin
                if ((pos & (1 << k)) != 0) p = p ^ ham[pos];
            end
            ham[1 << k] = p;
        end
        cw = ham;
        cw[0] = ^ham[HAM_N:1];
    end
endmodule

// File: rtl/ecc_sram_dec.sv
// Decoder: checks a SEC-DED codeword.
// Repairs one flipped bit (flagging single), or flags double without repair.
// Assumes the layout produced by ecc_sram_enc.
module ecc_sram_dec
    import ecc_sram_pkg::*;
(
    input  codeword_t cw,
    output byte_t     data,
    output logic      single,
    output logic      double
);
    logic [PAR_W-1:0] syn;
    logic             ovr;
    codeword_t        fixed;

    // Syndrome over Hamming positions; overall parity over the whole word
    always_comb begin
        syn = '0;
        for (int k = 0; k < PAR_W; k++) begin
            for (int pos = 1; pos <= HAM_N; pos++) begin
                if ((pos & (1 << k)) != 0) syn[k] = syn[k] ^ cw[pos];
            end
        end
        ovr = ^cw;
    end

    // Classify the error and repair at most one bit
    always_comb begin
        fixed  = cw;
        single = 1'b0;
        double = 1'b0;
        if (ovr) begin
            if (int'(syn) <= HAM_N) begin
                single = 1'b1;
                if (syn != '0) fixed[syn] = ~cw[syn];
            end else begin
                double = 1'b1;
            end
        end else if (syn != '0) begin
            double = 1'b1;
        end
    end

    // Pull the data bits back out of the non-check positions
    always_comb begin
        int d;
        data = '0;
        d = 0;
        for (int pos = 1; pos <= HAM_N; pos++) begin
            if (!is_check_pos(pos)) begin
                data[d] = fixed[pos];
                d = d + 1;
            end
        end
    end
endmodule

// File: rtl/ecc_sram_array.sv
// Codeword storage: one write port, one fault-injection port, one combinational read port.
// Assumes a write and an injection in the same cycle resolve in favour of the write.
// Storage is not reset; locations hold whatever was last written.
module ecc_sram_array
    import ecc_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  codeword_t        wr_cw,
    input  logic             inj_en,
    input  logic [IDX_W-1:0] inj_idx,
    input  codeword_t        inj_mask,
    input  logic [IDX_W-1:0] rd_idx,
    output codeword_t        rd_cw
);
    codeword_t mem [DEPTH];

    // Store a write, else flip the injected bits
    always_ff @(posedge clk) begin
        if (wr_en)       mem[wr_idx]  <= wr_cw;
        else if (inj_en) mem[inj_idx] <= mem[inj_idx] ^ inj_mask;
    end

    // Asynchronous read of the addressed codeword
    assign rd_cw = mem[rd_idx];
endmodule

// File: rtl/ecc_sram.sv
// Top: ECC-protected byte memory with a dual chip-enable, clock-sampled control interface.
// A read registers corrected data and error flags one cycle after the controls.
// Corrections are never written back to the array.
// Assumes DEPTH is a power of two no larger than 2**ADDR_W.
module ecc_sram
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              err,
    output logic              ue,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [12:0]       inj_mask
);
    logic      sel, wr, rd;
    codeword_t wr_cw, rd_cw;
    byte_t     rd_data;
    logic      rd_single, rd_double;
    logic      unused_hi;

    // Chip select and cycle type decode
    assign sel = !ce1_n && ce2;
    assign wr  = sel && !we_n;
    assign rd  = sel && we_n && !oe_n;

    // Upper address bits alias onto the built depth (R11)
    assign unused_hi = ^{addr[ADDR_W-1:IDX_W], inj_addr[ADDR_W-1:IDX_W]};

    ecc_sram_enc u_enc (
        .data (dq_in),
        .cw   (wr_cw)
    );

    ecc_sram_array #(.DEPTH(DEPTH)) u_array (
        .clk      (clk),
        .wr_en    (wr),
        .wr_idx   (addr[IDX_W-1:0]),
        .wr_cw    (wr_cw),
        .inj_en   (inj_en),
        .inj_idx  (inj_addr[IDX_W-1:0]),
        .inj_mask (inj_mask),
        .rd_idx   (addr[IDX_W-1:0]),
        .rd_cw    (rd_cw)
    );

    ecc_sram_dec u_dec (
        .cw     (rd_cw),
        .data   (rd_data),
        .single (rd_single),
        .double (rd_double)
    );

    // Register read data, bus enable and flags; all quiet outside a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            err    <= 1'b0;
            ue     <= 1'b0;
        end else if (rd) begin
            dq_out <= rd_data;
            dq_oe  <= 1'b1;
            err    <= rd_single;
            ue     <= rd_double;
        end else begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            err    <= 1'b0;
            ue     <= 1'b0;
        end
    end

    // Deselected cycle leaves the bus undriven next cycle
    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n || !ce2) |=> !dq_oe);

    // Selected read drives the bus next cycle
    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && ce2 && we_n && !oe_n) |=> dq_oe);

    // A write or a disabled output never drives the bus next cycle
    assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || oe_n) |=> !dq_oe);

    // Flags only accompany a driven bus
    assert_flags_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (!err && !ue));

    // Corrected and uncorrectable are mutually exclusive
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && ue));
endmodule

// File: tb/ecc_sram_tb.sv
// Directed bench for ecc_sram: one task per scenario, each checking its own results.
module ecc_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 21;
    localparam int DEPTH      = 256;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce1_n, ce2, we_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        dq_in;
    logic [7:0]        dq_out;
    logic              dq_oe, err, ue;
    logic              inj_en;
    logic [ADDR_W-1:0] inj_addr;
    logic [12:0]       inj_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .err(err), .ue(ue),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Drive one cycle at the falling edge; return after the next falling edge
    task automatic cyc(input logic c1n, input logic c2, input logic wn, input logic on,
                       input int a, input int d);
        @(negedge clk);
        ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on;
        addr = ADDR_W'(a); dq_in = 8'(d);
        @(negedge clk);
        ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1; inj_en = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, a, d);
    endtask

    task automatic rd_chk(input string req, input int a, input int d, input int e, input int u);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, a, 0);
        chk({req, " dq_oe"}, int'(dq_oe), 1);
        chk({req, " data"},  int'(dq_out), d);
        chk({req, " err"},   int'(err), e);
        chk({req, " ue"},    int'(ue), u);
    endtask

    task automatic inject(input int a, input int m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = ADDR_W'(a); inj_mask = 13'(m);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 dq_oe", int'(dq_oe), 0);
        chk("R10 dq_out", int'(dq_out), 0);
        chk("R10 err", int'(err), 0);
        chk("R10 ue", int'(ue), 0);
    endtask

    task automatic t_basic();
        wr(1, 8'hA5); wr(2, 8'h00); wr(3, 8'hFF); wr(200, 8'h3C);
        rd_chk("R2 R3 a1", 1, 8'hA5, 0, 0);
        rd_chk("R2 R3 a2", 2, 8'h00, 0, 0);
        rd_chk("R2 R3 a3", 3, 8'hFF, 0, 0);
        rd_chk("R2 R3 a200", 200, 8'h3C, 0, 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4, 8'h5A); // write with oe_n low
        chk("R4 write cycle dq_oe", int'(dq_oe), 0);
        chk("R8 write cycle err", int'(err), 0);
        rd_chk("R2 oe_n ignored", 4, 8'h5A, 0, 0);
    endtask

    task automatic t_select();
        wr(10, 8'h11);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 10, 8'h22);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 10, 8'h33);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 10, 8'h44);
        rd_chk("R1 deselected writes dropped", 10, 8'h11, 0, 0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 10, 0);
        chk("R1 read ce1_n high dq_oe", int'(dq_oe), 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 10, 0);
        chk("R1 read ce2 low dq_oe", int'(dq_oe), 0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 10, 0);
        chk("R4 oe_n high dq_oe", int'(dq_oe), 0);
    endtask

    task automatic t_single();
        for (int b = 0; b < 13; b++) begin
            wr(20, 8'h96);
            inject(20, 1 << b);
            rd_chk($sformatf("R5 bit %0d", b), 20, 8'h96, 1, 0);
            rd_chk($sformatf("R6 reread bit %0d", b), 20, 8'h96, 1, 0);
        end
        wr(20, 8'h96);
        rd_chk("R6 rewrite clears", 20, 8'h96, 0, 0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 20, 0);
        chk("R8 deselect err", int'(err), 0);
    endtask

    task automatic t_double();
        // positions 3,5 hold d0,d1; 7,12 hold d3,d7
        wr(30, 8'hC3); inject(30, (1 << 3) | (1 << 5));
        rd_chk("R7 data pair 3/5", 30, 8'hC3 ^ 8'h03, 0, 1);
        wr(31, 8'h5E); inject(31, (1 << 0) | (1 << 1));
        rd_chk("R7 parity pair 0/1", 31, 8'h5E, 0, 1);
        wr(32, 8'h70); inject(32, (1 << 7) | (1 << 12));
        rd_chk("R7 data pair 7/12", 32, 8'h70 ^ 8'h88, 0, 1);
        wr(33, 8'h01); inject(33, (1 << 2) | (1 << 4));
        rd_chk("R7 check pair 2/4", 33, 8'h01, 0, 1);
    endtask

    task automatic t_inject_priority();
        wr(40, 8'h0F);
        @(negedge clk);
        ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 41; dq_in = 8'hE1;
        inj_en = 1'b1; inj_addr = 40; inj_mask = 13'h0008;
        @(negedge clk);
        ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; inj_en = 1'b0;
        rd_chk("R9 injection dropped", 40, 8'h0F, 0, 0);
        rd_chk("R9 write won", 41, 8'hE1, 0, 0);
    endtask

    task automatic t_alias();
        wr(DEPTH + 7, 8'hB4);
        rd_chk("R11 alias read", 7, 8'hB4, 0, 0);
        inject(7 + 4 * DEPTH, 1 << 9);
        rd_chk("R11 alias inject", DEPTH * 3 + 7, 8'hB4, 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0; inj_en = 1'b0; inj_addr = '0; inj_mask = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_select();
        t_single();
        t_double();
        t_inject_priority();
        t_alias();
        done = 1;
        finish_run();
    end
endmodule